// File: doc/BRIEF.md
# I2C Configuration Register Bank Slave

This block is a two-wire serial slave that gives a host write and read access to a small bank of 8-bit configuration registers. A fast system clock samples both bus lines. The block recognises START, repeated START and STOP conditions. It answers a single 7-bit device address. The upper six address bits are fixed by a parameter, and the lowest bit follows a board strap pin. The register contents are presented continuously on a flat parallel output bus, so the rest of the chip can use the settings directly.

Each write transfer begins with an index byte after the address. The top bit of that byte chooses between two behaviours for later bytes in the same transfer. With the bit set, the bytes walk through consecutive registers. With the bit clear, every byte targets one register. Reads use the same index and the same walking rule. The slave pulls SDA low through an open-drain enable output and never holds SCL low.

Top module: `i2c_cfg_bank`

## Requirements
- R1: After reset every register reads 0x00, the index is 0 with the walk flag clear, and the SDA pull-down enable is inactive.
- R2: The slave acknowledges an address byte whose seven upper bits equal binary 100110 followed by the strap level. The eighth bit selects direction: 0 means write and 1 means read.
- R3: If the address does not match, SDA stays released for the acknowledge bit and for every later bit. The register contents stay unchanged until the next START or STOP.
- R4: The first byte of a write transfer after the address is the index byte. Bit 7 is the walk flag and bits 2:0 select the register. Bits 6:3 have no effect.
- R5: Each data byte of a write transfer is stored in the register that the index selects. Register i appears on regs_o[8*i+7 : 8*i].
- R6: With the walk flag set, the index advances by one after every data byte written or read, and wraps from 7 to 0.
- R7: With the walk flag clear, the index keeps its value, so repeated data bytes write or read the same register.
- R8: A read transfer returns, MSB first, the register that the index selects, one byte after another. The index advances after each byte sent, under the rule of R6 and R7. After the master answers a byte with NACK, the slave releases SDA.
- R9: The slave acknowledges the matching address byte, the index byte and every data byte of a write transfer by pulling SDA low for the acknowledge bit.
- R10: A STOP or a repeated START ends the current transfer. A data byte that is cut short is discarded, and the index and walk flag keep their values.
- R11: The slave changes its SDA pull-down enable only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| strap_i | input | 1 | Level that supplies the lowest device address bit |
| sda_oe_o | output | 1 | Pulls SDA low when 1 (open drain) |
| regs_o | output | 64 | All registers side by side, register 0 in the low byte |

## Verification
A data byte can write a register and advance the index on the same system clock edge, which is the falling SCL edge that ends the byte. A read can likewise send the register at the current index and step that index on one edge. The bench drives bursts with the walk flag set from index 5 through the wrap past index 7. It then reads the burst back across the same wrap. Every register is checked against an arithmetic model of the index after each transfer. A hold-mode burst is checked the same way, to confirm that the last byte wins and that neighbouring registers keep their values.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_PTR,
      ST_PTR_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK
   } cfgb_state_e;
endpackage

// File: rtl/cfgb_sync.sv
module cfgb_sync #(
   parameter int          W       = 2,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] q,
   output logic [W-1:0] q_prev
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cfgb_sync: STAGES must be at least 2");
   end

   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
         q_prev <= RST_VAL;
      end else begin
         pipe[0] <= din;
         for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
         q_prev <= pipe[STAGES-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/cfgb_link.sv
module cfgb_link
   import cfgb_pkg::*;
#(
   parameter int         DATA_W = 8,
   parameter int         IDX_W  = 3,
   parameter logic [5:0] DEV_HI = 6'b100110
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              scl_p,
   input  logic              sda_s,
   input  logic              sda_p,
   input  logic              strap,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_go,
   output logic [DATA_W-1:0] wr_data,
   output logic [IDX_W-1:0]  ptr_idx,
   output logic              ptr_incr,
   output logic              stop_ev,
   output logic              sda_oe
);
   localparam int CNT_W = $clog2(DATA_W) + 1;

   cfgb_state_e       st;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] sh;
   logic [DATA_W-1:0] tx;
   logic              rw;
   logic              mack;
   logic              start_ev;
   logic              scl_rise;
   logic              scl_fall;
   logic              byte_done;

   assign start_ev  = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_ev   = scl_s & scl_p & ~sda_p & sda_s;
   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign byte_done = scl_fall && (cnt == CNT_W'(DATA_W));
   assign wr_go     = (st == ST_WR) && byte_done && !start_ev && !stop_ev;
   assign wr_data   = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         sh       <= '0;
         tx       <= '0;
         rw       <= 1'b0;
         mack     <= 1'b0;
         sda_oe   <= 1'b0;
         ptr_idx  <= '0;
         ptr_incr <= 1'b0;
      end else if (start_ev) begin
         st     <= ST_ADDR;
         cnt    <= '0;
         sda_oe <= 1'b0;
      end else if (stop_ev) begin
         st     <= ST_IDLE;
         cnt    <= '0;
         sda_oe <= 1'b0;
      end else begin
         case (st)
            ST_ADDR, ST_PTR, ST_WR: begin
               if (scl_rise) begin
                  sh  <= {sh[DATA_W-2:0], sda_s};
                  cnt <= cnt + 1'b1;
               end else if (byte_done) begin
                  cnt <= '0;
                  if (st == ST_ADDR) begin
                     if (sh[DATA_W-1:1] == {DEV_HI, strap}) begin
                        rw     <= sh[0];
                        sda_oe <= 1'b1;
                        st     <= ST_ADDR_ACK;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end else if (st == ST_PTR) begin
                     ptr_idx  <= sh[IDX_W-1:0];
                     ptr_incr <= sh[DATA_W-1];
                     sda_oe   <= 1'b1;
                     st       <= ST_PTR_ACK;
                  end else begin
                     if (ptr_incr) ptr_idx <= ptr_idx + IDX_W'(1);
                     sda_oe <= 1'b1;
                     st     <= ST_WR_ACK;
                  end
               end
            end
            ST_ADDR_ACK: begin
               if (scl_fall) begin
                  cnt <= '0;
                  if (rw) begin
                     tx     <= rd_data;
                     sda_oe <= ~rd_data[DATA_W-1];
                     st     <= ST_RD;
                  end else begin
                     sda_oe <= 1'b0;
                     st     <= ST_PTR;
                  end
               end
            end
            ST_PTR_ACK, ST_WR_ACK: begin
               if (scl_fall) begin
                  sda_oe <= 1'b0;
                  st     <= ST_WR;
               end
            end
            ST_RD: begin
               if (scl_fall) begin
                  if (cnt == CNT_W'(DATA_W - 1)) begin
                     sda_oe <= 1'b0;
                     if (ptr_incr) ptr_idx <= ptr_idx + IDX_W'(1);
                     st <= ST_RD_ACK;
                  end else begin
                     tx     <= {tx[DATA_W-2:0], 1'b0};
                     sda_oe <= ~tx[DATA_W-2];
                     cnt    <= cnt + 1'b1;
                  end
               end
            end
            ST_RD_ACK: begin
               if (scl_rise) begin
                  mack <= ~sda_s;
               end else if (scl_fall) begin
                  cnt <= '0;
                  if (mack) begin
                     tx     <= rd_data;
                     sda_oe <= ~rd_data[DATA_W-1];
                     st     <= ST_RD;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/cfgb_store.sv
module cfgb_store #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_go,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic [IDX_W-1:0]              rd_idx,
   output logic [DATA_W-1:0]             rd_data,
   output logic [(2**IDX_W)*DATA_W-1:0]  regs_flat
);
   localparam int NREG = 2 ** IDX_W;

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 q <= '0;
         else if (wr_go && (wr_idx == IDX_W'(g)))    q <= wr_data;
      end
      assign regs_flat[g*DATA_W +: DATA_W] = q;
   end

   assign rd_data = regs_flat[rd_idx*DATA_W +: DATA_W];
endmodule

// File: rtl/i2c_cfg_bank.sv
module i2c_cfg_bank #(
   parameter int         DATA_W      = 8,
   parameter int         IDX_W       = 3,
   parameter int         SYNC_STAGES = 2,
   parameter logic [5:0] DEV_HI      = 6'b100110
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         scl_i,
   input  logic                         sda_i,
   input  logic                         strap_i,
   output logic                         sda_oe_o,
   output logic [(2**IDX_W)*DATA_W-1:0] regs_o
);
   if (DATA_W != 8) begin : g_bad_width
      $error("i2c_cfg_bank: DATA_W must be 8");
   end
   if (IDX_W < 1 || IDX_W > DATA_W - 1) begin : g_bad_idx
      $error("i2c_cfg_bank: IDX_W out of range");
   end

   logic [1:0]        bus_s;
   logic [1:0]        bus_p;
   logic              scl_s;
   logic              sda_s;
   logic              wr_go;
   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] rd_data;
   logic [IDX_W-1:0]  ptr_idx;
   logic              ptr_incr;
   logic              stop_ev;

   cfgb_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    ({scl_i, sda_i}),
      .q      (bus_s),
      .q_prev (bus_p)
   );

   assign scl_s = bus_s[1];
   assign sda_s = bus_s[0];

   cfgb_link #(.DATA_W(DATA_W), .IDX_W(IDX_W), .DEV_HI(DEV_HI)) u_link (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (scl_s),
      .scl_p    (bus_p[1]),
      .sda_s    (sda_s),
      .sda_p    (bus_p[0]),
      .strap    (strap_i),
      .rd_data  (rd_data),
      .wr_go    (wr_go),
      .wr_data  (wr_data),
      .ptr_idx  (ptr_idx),
      .ptr_incr (ptr_incr),
      .stop_ev  (stop_ev),
      .sda_oe   (sda_oe_o)
   );

   cfgb_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_go     (wr_go),
      .wr_idx    (ptr_idx),
      .wr_data   (wr_data),
      .rd_idx    (ptr_idx),
      .rd_data   (rd_data),
      .regs_flat (regs_o)
   );
endmodule

// File: rtl/cfgb_chk.sv
module cfgb_chk #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 3
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         scl_s,
   input logic                         sda_oe,
   input logic                         stop_ev,
   input logic                         wr_go,
   input logic [IDX_W-1:0]             ptr_idx,
   input logic                         ptr_incr,
   input logic [(2**IDX_W)*DATA_W-1:0] regs
);
   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (regs == '0) && !sda_oe);

   // R11
   oe_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_s);

   // R10
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> !sda_oe);

   // R6
   walk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && ptr_incr) |=> (ptr_idx == IDX_W'($past(ptr_idx) + 1'b1)));

   // R7
   hold_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && !ptr_incr) |=> $stable(ptr_idx));
endmodule

bind i2c_cfg_bank cfgb_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_s    (scl_s),
   .sda_oe   (sda_oe_o),
   .stop_ev  (stop_ev),
   .wr_go    (wr_go),
   .ptr_idx  (ptr_idx),
   .ptr_incr (ptr_incr),
   .regs     (regs_o)
);

// File: tb/i2c_cfg_bank_bench.sv
module i2c_cfg_bank_bench;
   localparam int Q = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1;
   logic        m_low = 1'b0;
   logic        strap = 1'b0;
   logic        sda_oe;
   logic [63:0] regs;
   logic        sda;

   assign sda = ~(m_low | sda_oe);

   always #5 clk = ~clk;

   i2c_cfg_bank u_i2c_cfg_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl),
      .sda_i    (sda),
      .strap_i  (strap),
      .sda_oe_o (sda_oe),
      .regs_o   (regs)
   );

   int         total = 0;
   int         bad = 0;
   logic [7:0] model [8];
   int         m_ptr = 0;
   bit         m_incr = 1'b0;
   logic [7:0] dbuf [16];

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wq(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic put_bit(bit b);
      m_low = ~b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
   endtask

   task automatic start_c;
      m_low = 1'b0; wq(Q); scl = 1'b1; wq(Q); m_low = 1'b1; wq(Q); scl = 1'b0; wq(Q);
   endtask

   task automatic stop_c;
      m_low = 1'b1; wq(Q); scl = 1'b1; wq(Q); m_low = 1'b0; wq(2*Q);
   endtask

   task automatic send_byte(logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) put_bit(b[i]);
      m_low = 1'b0; wq(Q); scl = 1'b1; wq(Q); ack = ~sda; wq(Q); scl = 1'b0; wq(Q);
   endtask

   task automatic get_byte(bit ack_it, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         m_low = 1'b0; wq(Q); scl = 1'b1; wq(Q); b[i] = sda; wq(Q); scl = 1'b0; wq(Q);
      end
      m_low = ack_it; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q); m_low = 1'b0;
   endtask

   function automatic logic [7:0] addr_byte(bit rd);
      return {6'b100110, strap, rd};
   endfunction

   // write transfer: index byte p, then n bytes from dbuf; optional stop
   task automatic wr_seq(logic [7:0] p, int n, bit do_stop);
      bit ack;
      start_c;
      send_byte(addr_byte(1'b0), ack); chk("R2 address ack", ack, 1);
      send_byte(p, ack);               chk("R9 index ack", ack, 1);
      m_ptr = int'(p[2:0]); m_incr = p[7];
      for (int k = 0; k < n; k++) begin
         send_byte(dbuf[k], ack);      chk("R9 data ack", ack, 1);
         model[m_ptr] = dbuf[k];
         if (m_incr) m_ptr = (m_ptr + 1) % 8;
      end
      if (do_stop) stop_c;
   endtask

   task automatic rd_seq(string req, int n);
      bit ack;
      logic [7:0] b;
      start_c;
      send_byte(addr_byte(1'b1), ack); chk("R2 read address ack", ack, 1);
      for (int k = 0; k < n; k++) begin
         get_byte(k < n - 1, b);
         chk(req, b, model[m_ptr]);
         if (m_incr) m_ptr = (m_ptr + 1) % 8;
      end
      chk("R8 released after NACK", sda, 1);
      stop_c;
   endtask

   task automatic cmp_all(string req);
      for (int i = 0; i < 8; i++) chk(req, regs[i*8 +: 8], model[i]);
   endtask

   initial begin
      wq(3000 * 50);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      bit ack;
      for (int i = 0; i < 8; i++) model[i] = 8'h00;
      wq(5); rst_n = 1'b1; wq(5);

      // R1 reset state
      chk("R1 regs zero", regs, 0);
      chk("R1 sda released", sda_oe, 0);
      dbuf[0] = 8'h3C; dbuf[1] = 8'hC3;
      start_c;
      send_byte(addr_byte(1'b0), ack); chk("R1 address ack", ack, 1);
      send_byte(dbuf[0], ack);
      send_byte(dbuf[1], ack);
      stop_c;
      // R1: reset index 0 is taken as the first byte (index byte 0x3C -> idx 4, hold)
      model[4] = 8'hC3; m_ptr = 4; m_incr = 1'b0;
      cmp_all("R1 first byte is index");

      // R4 R5 sweep: each register, hold mode, junk in bits 6:3
      for (int i = 0; i < 8; i++) begin
         dbuf[0] = 8'(8'h11 * i) ^ 8'hA5;
         wr_seq({1'b0, 4'(15 - i), 3'(i)}, 1, 1'b1);
         cmp_all("R5 single write");
      end
      cmp_all("R4 middle bits ignored");

      // R7 hold mode, last byte wins
      dbuf[0] = 8'h01; dbuf[1] = 8'h02; dbuf[2] = 8'h7E;
      wr_seq(8'h03, 3, 1'b1);
      cmp_all("R7 hold write");

      // R6 walk from 5 across wrap
      for (int k = 0; k < 8; k++) dbuf[k] = 8'(8'h40 + 8'h13 * k);
      wr_seq(8'h85, 8, 1'b1);
      cmp_all("R6 walk wrap");

      // R8 read back walking from 6 across wrap
      wr_seq(8'h86, 0, 1'b1);
      rd_seq("R8 walk read", 8);
      // R7 hold read
      wr_seq(8'h02, 0, 1'b1);
      rd_seq("R7 hold read", 3);

      // R3 mismatch with strap high
      strap = 1'b1;
      start_c;
      send_byte({6'b100110, 1'b0, 1'b0}, ack); chk("R3 no ack", ack, 0);
      send_byte(8'h81, ack);                   chk("R3 index ignored", ack, 0);
      send_byte(8'hEE, ack);                   chk("R3 data ignored", ack, 0);
      stop_c;
      cmp_all("R3 regs unchanged");
      start_c;
      send_byte({6'b100111, 1'b1, 1'b0}, ack); chk("R3 upper bits no ack", ack, 0);
      stop_c;
      // R2 strap level 1 accepted
      dbuf[0] = 8'h5A;
      wr_seq(8'h01, 1, 1'b1);
      cmp_all("R2 strap high write");

      // R10 repeated start turns a write into a read
      dbuf[0] = 8'hD7;
      wr_seq(8'h80, 1, 1'b0);
      rd_seq("R10 repeated start read", 2);
      cmp_all("R10 after repeated start");

      // R10 stop cuts a data byte short
      start_c;
      send_byte(addr_byte(1'b0), ack); chk("R10 address ack", ack, 1);
      send_byte(8'h87, ack);           chk("R10 index ack", ack, 1);
      m_ptr = 7; m_incr = 1'b1;
      for (int i = 0; i < 4; i++) put_bit(1'b1);
      m_low = 1'b0; wq(Q);
      stop_c;
      cmp_all("R10 partial byte dropped");
      rd_seq("R10 index kept", 2);
      chk("R11 released at end", sda_oe, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule